// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block carries out one atomic memory request at a time against a single-port word memory. It supports a load-reserved / store-conditional pair, and nine read-modify-write operations that return the word's previous value and store a combined result. A single reservation register records the address claimed by the last load-reserved. A snoop input reports stores made by other agents. A snooped store to the reserved word cancels the reservation.

A request is taken while `req_ready` is high. The unit steps through read, compute, write and respond phases as the operation requires. It skips the read for a swap whose result is discarded. It skips the write when the computed word equals the word already in memory. The acquire and release bits travel with the request and come out as one-cycle ordering pulses. The unit does not order them against any other traffic.

Top module: `amo_unit`

## Requirements
- R1: After reset the unit is idle: `req_ready`=1, `mem_req`=0, `rsp_valid`=0, and no reservation is held, so a store-conditional issued first fails.
- R2: Load-reserved (op code 0) reads the addressed word, returns it on `rsp_data`, and records a reservation on that word address.
- R3: Store-conditional (op code 1) writes `req_data` and returns 0 only when the reservation is valid and its address equals the request address.
- R4: A failing store-conditional returns 1 and makes no memory write.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails, and whatever address it names.
- R6: A snoop (`snoop_valid`=1) whose address equals the reserved address clears the reservation, and this takes effect even for a store-conditional accepted in the same cycle. A snoop to any other address leaves the reservation in place.
- R7: Read-modify-write op codes are 2 swap, 3 add, 4 and, 5 or, 6 xor. Each returns the old word and leaves the result in memory. Add wraps modulo 2^DW.
- R8: Op codes 7/8 are signed min/max in two's complement, and 9/10 are unsigned min/max.
- R9: When the computed result equals the old word, no memory write is issued.
- R10: A swap with `req_rd_zero`=1 issues no memory read, writes `req_data`, and returns 0.
- R11: `fence_acq` pulses in the accept cycle of a request with `req_aq`=1. `fence_rel` is high in the response cycle of a request with `req_rl`=1.
- R12: Only one operation is in flight: `req_ready` is low from acceptance until after the one-cycle `rsp_valid` pulse, and `mem_we` is never high without `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Word address |
| req_data | input | DW | Operand / store data |
| req_rd_zero | input | 1 | Result of the request is discarded |
| req_aq | input | 1 | Acquire ordering requested |
| req_rl | input | 1 | Release ordering requested |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DW | Old word, or store-conditional status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory access completes |
| snoop_valid | input | 1 | Another agent stores this cycle |
| snoop_addr | input | AW | Word address of that store |
| fence_acq | output | 1 | Acquire ordering pulse |
| fence_rel | output | 1 | Release ordering pulse |

## Verification
Every read-modify-write code is swept over all pairs from an 8-bit value set. The set holds zero, one, both sign boundaries, all-ones and mixed patterns. This separates signed from unsigned ordering, shows add wrap-around, and produces equal-result pairs that must skip the write. Reservation sequences are run separately: a matching pair, a repeated store-conditional, a mismatched address, a snoop to the reserved word, a snoop to another word, and a snoop that arrives in the same cycle as the store-conditional. Together they tell a live reservation apart from a cleared one. A discarded-result swap is counted for reads, and the fence pulses are sampled in the accept and response cycles.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [3:0] {
        OP_LR   = 4'd0,
        OP_SC   = 4'd1,
        OP_SWAP = 4'd2,
        OP_ADD  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_MIN  = 4'd7,
        OP_MAX  = 4'd8,
        OP_MINU = 4'd9,
        OP_MAXU = 4'd10
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COMPUTE,
        ST_WRITE,
        ST_RESPOND
    } amo_state_e;

    localparam logic [3:0] OP_CODE_W = 4'd4;

endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 32
) (
    input  amo_op_e         op,
    input  logic [DW-1:0]   mem_val,
    input  logic [DW-1:0]   opnd,
    output logic [DW-1:0]   result
);
    logic s_lt;
    logic u_lt;

    always_comb begin
        s_lt = $signed(opnd) < $signed(mem_val);
        u_lt = opnd < mem_val;
        case (op)
            OP_SWAP: result = opnd;
            OP_ADD:  result = mem_val + opnd;
            OP_AND:  result = mem_val & opnd;
            OP_OR:   result = mem_val | opnd;
            OP_XOR:  result = mem_val ^ opnd;
            OP_MIN:  result = s_lt ? opnd : mem_val;
            OP_MAX:  result = s_lt ? mem_val : opnd;
            OP_MINU: result = u_lt ? opnd : mem_val;
            OP_MAXU: result = u_lt ? mem_val : opnd;
            default: result = mem_val;
        endcase
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set,
    input  logic [AW-1:0] set_addr,
    input  logic          clear,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic [AW-1:0] chk_addr,
    output logic          valid,
    output logic          match,
    output logic          snoop_hit
);
    logic [AW-1:0] addr_q;

    assign snoop_hit = snoop_valid && valid && (snoop_addr == addr_q);
    assign match     = valid && !snoop_hit && (addr_q == chk_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            addr_q <= '0;
        end else if (set) begin
            valid  <= 1'b1;
            addr_q <= set_addr;
        end else if (clear || snoop_hit) begin
            valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_rd_zero,
    input  logic          req_aq,
    input  logic          req_rl,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          fence_acq,
    output logic          fence_rel
);
    amo_state_e    state_q;
    amo_op_e       op_q;
    amo_op_e       op_in;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] opnd_q;
    logic [DW-1:0] old_q;
    logic [DW-1:0] res_q;
    logic [DW-1:0] alu_res;
    logic          rl_q;
    logic          accept;
    logic          resv_set;
    logic          resv_clear;
    logic          resv_valid;
    logic          resv_match;
    logic          snoop_hit;

    assign op_in      = amo_op_e'(req_op);
    assign accept     = req_valid && (state_q == ST_IDLE);
    assign resv_clear = accept && (op_in == OP_SC);
    assign resv_set   = (state_q == ST_READ) && mem_ready && (op_q == OP_LR);

    amo_resv #(.AW(AW)) u_resv (
        .clk         (clk),
        .rst         (rst),
        .set         (resv_set),
        .set_addr    (addr_q),
        .clear       (resv_clear),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .chk_addr    (req_addr),
        .valid       (resv_valid),
        .match       (resv_match),
        .snoop_hit   (snoop_hit)
    );

    amo_alu #(.DW(DW)) u_alu (
        .op      (op_q),
        .mem_val (old_q),
        .opnd    (opnd_q),
        .result  (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LR;
            addr_q  <= '0;
            opnd_q  <= '0;
            old_q   <= '0;
            res_q   <= '0;
            rl_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= op_in;
                        addr_q <= req_addr;
                        opnd_q <= req_data;
                        rl_q   <= req_rl;
                        if (op_in == OP_SC) begin
                            if (resv_match) begin
                                res_q   <= req_data;
                                old_q   <= '0;
                                state_q <= ST_WRITE;
                            end else begin
                                old_q   <= DW'(1);
                                state_q <= ST_RESPOND;
                            end
                        end else if (op_in == OP_SWAP && req_rd_zero) begin
                            res_q   <= req_data;
                            old_q   <= '0;
                            state_q <= ST_WRITE;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        old_q   <= mem_rdata;
                        state_q <= (op_q == OP_LR) ? ST_RESPOND : ST_COMPUTE;
                    end
                end
                ST_COMPUTE: begin
                    res_q   <= alu_res;
                    state_q <= (alu_res == old_q) ? ST_RESPOND : ST_WRITE;
                end
                ST_WRITE: begin
                    if (mem_ready) state_q <= ST_RESPOND;
                end
                ST_RESPOND: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_addr  = addr_q;
    assign mem_wdata = res_q;
    assign rsp_valid = (state_q == ST_RESPOND);
    assign rsp_data  = old_q;
    assign fence_acq = accept && req_aq;
    assign fence_rel = (state_q == ST_RESPOND) && rl_q;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic mem_req,
    input logic mem_we,
    input logic rsp_valid,
    input logic fence_rel,
    input logic resv_valid,
    input logic resv_set,
    input logic snoop_hit
);
    p_idle_no_mem_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

    p_we_with_req_r12: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    p_rsp_single_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready);

    p_snoop_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (snoop_hit && !resv_set) |=> !resv_valid);

    p_lr_sets_r2: assert property (@(posedge clk) disable iff (rst)
        resv_set |=> resv_valid);

    p_rel_in_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        fence_rel |-> rsp_valid);
endmodule

bind amo_unit amo_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .rsp_valid  (rsp_valid),
    .fence_rel  (fence_rel),
    .resv_valid (resv_valid),
    .resv_set   (resv_set),
    .snoop_hit  (snoop_hit)
);

// File: tb/test_amo_unit.sv
`timescale 1ns/1ps
module test_amo_unit;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [3:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_rd_zero = 1'b0;
    logic          req_aq = 1'b0;
    logic          req_rl = 1'b0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ready;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          fence_acq;
    logic          fence_rel;

    logic [DW-1:0] mem [16];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    assign mem_ready = mem_req;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_req && !mem_we) rd_cnt <= rd_cnt + 1;
    end

    amo_unit #(.AW(AW), .DW(DW)) i_amo_unit (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_rd_zero(req_rd_zero),
        .req_aq(req_aq), .req_rl(req_rl),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .fence_acq(fence_acq), .fence_rel(fence_rel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent model of the combine step.
    function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] fa, fb;
        fa = a ^ 8'h80;
        fb = b ^ 8'h80;
        case (op)
            2:  return b;
            3:  return DW'((int'(a) + int'(b)) % 256);
            4:  return ~(~a | ~b);
            5:  return ~(~a & ~b);
            6:  return (a | b) & ~(a & b);
            7:  return (fa <= fb) ? a : b;
            8:  return (fa >= fb) ? a : b;
            9:  return (a <= b) ? a : b;
            10: return (a >= b) ? a : b;
            default: return a;
        endcase
    endfunction

    logic [DW-1:0] r_data;
    int            r_nw, r_nr;
    logic          r_acq, r_rel, r_busy;
    logic          snp_with_req = 1'b0;
    logic [AW-1:0] snp_with_addr = '0;

    task automatic run_op(input int op, input int addr, input logic [DW-1:0] data,
                          input logic rdz, input logic aq, input logic rl);
        int w0, r0, guard;
        @(negedge clk);
        w0 = wr_cnt; r0 = rd_cnt;
        req_valid = 1'b1; req_op = 4'(op); req_addr = AW'(addr); req_data = data;
        req_rd_zero = rdz; req_aq = aq; req_rl = rl;
        snoop_valid = snp_with_req; snoop_addr = snp_with_addr;
        #1 r_acq = fence_acq;
        @(negedge clk);
        req_valid = 1'b0; req_rd_zero = 1'b0; req_aq = 1'b0; req_rl = 1'b0;
        snoop_valid = 1'b0;
        r_busy = !req_ready;
        guard = 0;
        while (!rsp_valid && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        r_data = rsp_data;
        r_rel = fence_rel;
        @(negedge clk);
        r_nw = wr_cnt - w0;
        r_nr = rd_cnt - r0;
    endtask

    task automatic snoop_pulse(input int addr);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = AW'(addr);
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        summary();
    end

    logic [DW-1:0] vals [8];

    initial begin
        vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h7F; vals[3] = 8'h80;
        vals[4] = 8'hFF; vals[5] = 8'h55; vals[6] = 8'h2A; vals[7] = 8'hC3;
        for (int k = 0; k < 16; k++) mem[k] = DW'(k * 17);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 req_ready", req_ready, 1);
        check("R1 mem_req", mem_req, 0);
        check("R1 rsp_valid", rsp_valid, 0);
        run_op(1, 5, 8'hAA, 0, 0, 0);
        check("R1 sc after reset status", r_data, 1);
        check("R1 sc after reset no write", r_nw, 0);

        // R2/R3/R5: matching pair, then repeat
        mem[5] = 8'h3C;
        run_op(0, 5, 8'h00, 0, 0, 0);
        check("R2 lr value", r_data, 8'h3C);
        check("R12 busy after accept", r_busy, 1);
        run_op(1, 5, 8'h99, 0, 0, 0);
        check("R3 sc success", r_data, 0);
        check("R3 sc wrote", mem[5], 8'h99);
        run_op(1, 5, 8'h11, 0, 0, 0);
        check("R5 second sc fails", r_data, 1);
        check("R4 failed sc no write", mem[5], 8'h99);

        // R5: mismatched address clears
        run_op(0, 6, 0, 0, 0, 0);
        run_op(1, 7, 8'h44, 0, 0, 0);
        check("R3 sc wrong addr fails", r_data, 1);
        check("R4 wrong addr no write", r_nw, 0);
        run_op(1, 6, 8'h44, 0, 0, 0);
        check("R5 cleared by wrong-addr sc", r_data, 1);

        // R6: snoops
        run_op(0, 8, 0, 0, 0, 0);
        snoop_pulse(8);
        run_op(1, 8, 8'h12, 0, 0, 0);
        check("R6 snoop hit kills sc", r_data, 1);
        run_op(0, 8, 0, 0, 0, 0);
        snoop_pulse(9);
        run_op(1, 8, 8'h12, 0, 0, 0);
        check("R6 other snoop keeps resv", r_data, 0);
        check("R6 sc stored", mem[8], 8'h12);
        run_op(0, 10, 0, 0, 0, 0);
        snp_with_req = 1'b1; snp_with_addr = 4'd10;
        run_op(1, 10, 8'h77, 0, 0, 0);
        snp_with_req = 1'b0;
        check("R6 same-cycle snoop kills sc", r_data, 1);
        check("R6 same-cycle no write", r_nw, 0);

        // R10: discarded swap
        mem[11] = 8'h21;
        run_op(2, 11, 8'h5A, 1, 0, 0);
        check("R10 no read", r_nr, 0);
        check("R10 returns zero", r_data, 0);
        check("R10 wrote", mem[11], 8'h5A);

        // R11: fences
        run_op(3, 12, 8'h01, 0, 1, 1);
        check("R11 acquire pulse", r_acq, 1);
        check("R11 release pulse", r_rel, 1);
        run_op(3, 12, 8'h01, 0, 0, 0);
        check("R11 no acquire", r_acq, 0);
        check("R11 no release", r_rel, 0);

        // R7/R8/R9 sweep
        for (int op = 2; op <= 10; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [DW-1:0] e;
                    mem[3] = vals[i];
                    e = model(op, vals[i], vals[j]);
                    run_op(op, 3, vals[j], 0, 0, 0);
                    check((op >= 7) ? "R8 old value" : "R7 old value", r_data, vals[i]);
                    check((op >= 7) ? "R8 result" : "R7 result", mem[3], e);
                    check("R9 write count", r_nw, (e != vals[i]) ? 1 : 0);
                end
            end
        end
        summary();
    end
endmodule